// File: doc/BRIEF.md
# Shift-and-Store LED Sink Driver

This block turns a serial bit stream into a set of parallel LED sink controls. Bits are clocked into a chain of shift stages. A strobe copies the whole chain into a storage stage, so the visible pattern changes only when the controller chooses. Each stored bit drives one current-sink output. A 1 pulls the LED line low and a 0 releases it. An output-enable input can release every line at once without touching the stored pattern, which lets a dimming signal gate the display.

Two serial tail outputs let several drivers be chained into one long register. The fast tail is the last shift stage and changes on the rising edge. The slow tail holds the same bit but moves only on the following falling edge. That half-cycle of hold time suits a chain whose clock edges arrive late at the next device. Reset is synchronous and active high. The storage stage is a register that samples the chain on each rising edge that finds the strobe high.

Top module: `ledsr_driver`

## Requirements
- R1: While `rst` is high at a rising edge, every shift stage, every stored bit, every `sink_en` bit and `tail_fast` become 0. `tail_slow` becomes 0 at the next falling edge that samples `rst` high.
- R2: At each rising edge with `rst` low, stage 0 takes `ser_in`, and every stage i above 0 takes the old content of stage i-1. A bit entered at one edge reaches the last stage (index STAGES-1) after exactly STAGES rising edges.
- R3: `tail_fast` is the last shift stage. After each rising edge it equals the bit that stage STAGES-2 held just before that edge.
- R4: `tail_slow` takes the value of `tail_fast` at each falling edge. It does not change at a rising edge.
- R5: At a rising edge with `strobe` high, every stored bit i takes the pre-edge content of shift stage i. The shift happens at that same edge.
- R6: At a rising edge with `strobe` low, the stored bits keep their values, even while the chain shifts.
- R7: At a rising edge with `out_en` low, every `sink_en` bit becomes 0 (released), whatever is stored.
- R8: At a rising edge with `out_en` high, `sink_en[i]` takes the new value of stored bit i. In that bit, 1 means drive low and 0 means released.
- R9: Two instances can be chained by feeding the first instance's `tail_fast` or `tail_slow` into the second instance's `ser_in`. After 2*STAGES bits d0 (first) to d(2*STAGES-1) and one strobe edge, bit j of the first instance holds d(2*STAGES-1-j), and bit j of the second instance holds d(STAGES-1-j).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock. The chain moves on rising edges and the slow tail on falling edges. |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | Copies the shift stages into storage at a rising edge |
| out_en | input | 1 | High enables the sinks; low releases them all |
| sink_en | output | STAGES | Per-line sink control, 1 = drive low, 0 = released |
| tail_fast | output | 1 | Last shift stage, changes on the rising edge |
| tail_slow | output | 1 | Last-stage bit retimed to the falling edge |

## Verification
The bench builds four instances, all with the default of eight stages. Two of them are paired through the fast tail and two through the slow tail. Each pair forms a sixteen-bit chain, so the bench can check that bits cross the device boundary in order and that the slow tail keeps its half-cycle hold. The eight-stage width also keeps the full shift latency, the strobe capture and the retention of stored data during further shifting within short directed sequences.

// File: rtl/ledsr_pkg.sv
package ledsr_pkg;

  // Default length of the shift chain and of the storage stage
  parameter int unsigned LEDSR_DEF_STAGES = 8;

  // State of one sink line
  typedef enum logic {
    LINE_RELEASED = 1'b0,
    LINE_SINK     = 1'b1
  } line_drive_e;

endpackage

// File: rtl/ledsr_shift_chain.sv
module ledsr_shift_chain #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  output logic [STAGES-1:0] stage_o
);

  logic [STAGES-1:0] stage_q;

  // One flop per stage. Stage 0 is fed from the serial input and each
  // later stage is fed from its lower neighbour.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= ser_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign stage_o = stage_q;

endmodule

// File: rtl/ledsr_hold_store.sv
module ledsr_hold_store
  import ledsr_pkg::*;
#(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              out_en,
  input  logic [STAGES-1:0] stage_i,
  output logic [STAGES-1:0] store_o,
  output logic [STAGES-1:0] sink_o
);

  logic [STAGES-1:0] store_q;
  logic [STAGES-1:0] sink_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_bit
    logic store_nxt;
    line_drive_e drive_nxt;

    // The stored bit follows its stage on strobe edges and holds otherwise.
    assign store_nxt = strobe ? stage_i[g] : store_q[g];
    assign drive_nxt = (out_en && store_nxt) ? LINE_SINK : LINE_RELEASED;

    always_ff @(posedge clk) begin
      if (rst) begin
        store_q[g] <= 1'b0;
        sink_q[g]  <= 1'b0;
      end else begin
        store_q[g] <= store_nxt;
        sink_q[g]  <= drive_nxt;
      end
    end
  end

  assign store_o = store_q;
  assign sink_o  = sink_q;

endmodule

// File: rtl/ledsr_cascade_tap.sv
module ledsr_cascade_tap (
  input  logic clk,
  input  logic rst,
  input  logic tail_i,
  output logic slow_o
);

  logic slow_q;

  // Re-times the chain tail to the falling edge to add half a period of hold.
  always_ff @(negedge clk) begin
    if (rst) slow_q <= 1'b0;
    else     slow_q <= tail_i;
  end

  assign slow_o = slow_q;

endmodule

// File: rtl/ledsr_driver.sv
module ledsr_driver
  import ledsr_pkg::*;
#(
  parameter int unsigned STAGES = LEDSR_DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              strobe,
  input  logic              out_en,
  output logic [STAGES-1:0] sink_en,
  output logic              tail_fast,
  output logic              tail_slow
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] store_q;

  ledsr_shift_chain #(
    .STAGES (STAGES)
  ) u_chain (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .stage_o (stage_q)
  );

  ledsr_hold_store #(
    .STAGES (STAGES)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .out_en  (out_en),
    .stage_i (stage_q),
    .store_o (store_q),
    .sink_o  (sink_en)
  );

  assign tail_fast = stage_q[LAST];

  ledsr_cascade_tap u_tap (
    .clk    (clk),
    .rst    (rst),
    .tail_i (stage_q[LAST]),
    .slow_o (tail_slow)
  );

endmodule

// File: rtl/ledsr_driver_chk.sv
module ledsr_driver_chk #(
  parameter int unsigned STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_in,
  input logic              strobe,
  input logic              out_en,
  input logic [STAGES-1:0] stage,
  input logic [STAGES-1:0] store,
  input logic [STAGES-1:0] sink_en,
  input logic              tail_fast,
  input logic              tail_slow
);

  p_head_takes_input_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> stage[0] == $past(ser_in));

  p_tail_from_prev_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> tail_fast == $past(stage[STAGES-2]));

  p_slow_follows_r4: assert property (@(negedge clk) disable iff (rst)
    !rst |=> tail_slow == $past(tail_fast));

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> store == $past(stage));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(store));

  p_released_r7: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> sink_en == '0);

  p_sink_map_r8: assert property (@(posedge clk) disable iff (rst)
    out_en |=> sink_en == store);

endmodule

bind ledsr_driver ledsr_driver_chk #(
  .STAGES (STAGES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ser_in    (ser_in),
  .strobe    (strobe),
  .out_en    (out_en),
  .stage     (stage_q),
  .store     (store_q),
  .sink_en   (sink_en),
  .tail_fast (tail_fast),
  .tail_slow (tail_slow)
);

// File: tb/test_ledsr_driver.sv
`timescale 1ns/100ps
module test_ledsr_driver;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic strb = 1'b0;
  logic oe = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] sink_a, sink_b, sink_c, sink_d;
  logic fa, sa, fb, sb, fc, sc, fd, sd;

  // Pair A->B chained through the fast tail
  ledsr_driver #(.STAGES(N)) i_ledsr_driver (
    .clk(clk), .rst(rst), .ser_in(din), .strobe(strb), .out_en(oe),
    .sink_en(sink_a), .tail_fast(fa), .tail_slow(sa));
  ledsr_driver #(.STAGES(N)) i_fast_next (
    .clk(clk), .rst(rst), .ser_in(fa), .strobe(strb), .out_en(oe),
    .sink_en(sink_b), .tail_fast(fb), .tail_slow(sb));
  // Pair C->D chained through the slow tail
  ledsr_driver #(.STAGES(N)) i_slow_head (
    .clk(clk), .rst(rst), .ser_in(din), .strobe(strb), .out_en(oe),
    .sink_en(sink_c), .tail_fast(fc), .tail_slow(sc));
  ledsr_driver #(.STAGES(N)) i_slow_next (
    .clk(clk), .rst(rst), .ser_in(sc), .strobe(strb), .out_en(oe),
    .sink_en(sink_d), .tail_fast(fd), .tail_slow(sd));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [N-1:0] m_stage = '0;
  logic [N-1:0] m_store = '0;
  logic [N-1:0] m_sink  = '0;
  logic slow_seen, slow_exp, slow_post;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, sample just after the rising edge
  task automatic step(input logic d, input logic s, input logic o, input logic r);
    @(negedge clk); #1;
    slow_seen = sa;
    slow_exp  = m_stage[N-1];
    din = d; strb = s; oe = o; rst = r;
    @(posedge clk); #1;
    slow_post = sa;
    if (r) begin
      m_stage = '0; m_store = '0; m_sink = '0;
    end else begin
      if (s) m_store = m_stage;
      m_stage = {m_stage[N-2:0], d};
      m_sink  = o ? m_store : '0;
    end
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R1 sink after reset", 32'(sink_a), 32'h0);
    chk("R1 fast tail after reset", 32'(fa), 32'h0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 slow tail after reset", 32'(slow_seen), 32'h0);
  endtask

  task automatic t_shift;
    // A single 1 into zeros must surface on the tail after exactly N edges
    for (int k = 0; k < N; k++) begin
      step(k == 0, 1'b0, 1'b0, 1'b0);
      chk("R2 single bit latency", 32'(fa), (k == N-1) ? 32'h1 : 32'h0);
    end
    for (int k = 0; k < 12; k++) begin
      step(k[0] ^ k[2], 1'b0, 1'b0, 1'b0);
      chk("R3 fast tail tracks stage", 32'(fa), 32'(m_stage[N-1]));
    end
  endtask

  task automatic t_slow;
    for (int k = 0; k < 10; k++) begin
      step(k[1], 1'b0, 1'b0, 1'b0);
      chk("R4 slow tail at falling edge", 32'(slow_seen), 32'(slow_exp));
      chk("R4 slow tail stable at rising edge", 32'(slow_post), 32'(slow_seen));
    end
  endtask

  task automatic t_capture(input logic [N-1:0] v);
    for (int k = 0; k < N; k++) step(v[N-1-k], 1'b0, 1'b1, 1'b0);
    chk("R6 no capture without strobe", 32'(sink_a), 32'(m_sink));
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5 strobe captures chain", 32'(sink_a), 32'(v));
    chk("R8 sink mirrors store", 32'(sink_a), 32'(m_sink));
  endtask

  task automatic t_hold(input logic [N-1:0] v);
    for (int k = 0; k < N; k++) begin
      step(~v[k], 1'b0, 1'b1, 1'b0);
      chk("R6 store holds while shifting", 32'(sink_a), 32'(v));
    end
  endtask

  task automatic t_oe(input logic [N-1:0] v);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 outputs released", 32'(sink_a), 32'h0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 outputs stay released", 32'(sink_a), 32'h0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8 sinks return with stored data", 32'(sink_a), 32'(v));
  endtask

  task automatic t_cascade(input logic [2*N-1:0] pat);
    logic [N-1:0] ea, eb;
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 2*N; k++) step(pat[k], 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    for (int j = 0; j < N; j++) begin
      ea[j] = pat[2*N-1-j];
      eb[j] = pat[N-1-j];
    end
    chk("R9 head via fast tail", 32'(sink_a), 32'(ea));
    chk("R9 second via fast tail", 32'(sink_b), 32'(eb));
    chk("R9 head via slow tail", 32'(sink_c), 32'(ea));
    chk("R9 second via slow tail", 32'(sink_d), 32'(eb));
  endtask

  initial begin
    t_reset();
    t_shift();
    t_slow();
    t_capture(8'hC6);
    t_hold(8'hC6);
    t_oe(8'hC6);
    t_capture(8'h3B);
    t_cascade(16'hB38E);
    t_cascade(16'h1F60);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule